// File: doc/BRIEF.md
# Store and Fence Commit Gate

This block decides, every cycle, whether the oldest pending store and a pending fence may commit, given a scoreboard of in-flight instructions. Each scoreboard slot describes one instruction by kind (load, store, branch or indirect jump, normal fence, total-store-order fence, or other), the four fence ordering bits, acquire and release annotations, a finished flag and a flag saying whether its memory address is known. Slot index gives age: a lower index is older. The candidate store and the candidate fence each state their own age position, and only valid slots with an index below that position count as older.

The two combinational verdicts `st_ok` and `fn_ok` are visible at once. Each also feeds a small handshake state machine with the states IDLE (no request), WAIT (request present but blocked) and GRANT (commit granted, waiting for acknowledge). The transitions are: IDLE to GRANT on request with permission, IDLE to WAIT on request without permission, WAIT to GRANT once permission appears, WAIT to IDLE when the request drops, and GRANT to IDLE on acknowledge. The grant is a decoded register, so it is asserted one clock after the verdict is seen with a request. A store decision and a fence decision can be granted in the same cycle.

Top module: `commit_gate`

## Requirements
- R1: With no older valid slot and `st_data_rdy` high, `st_ok` is 1.
- R2: `st_ok` is 0 while `st_data_rdy` is 0.
- R3: An older unfinished slot of kind branch/jump (code 2) forces `st_ok` to 0.
- R4: An older unfinished normal fence (code 3) whose sw bit (`sb_fbits` bit 0) is set, or any older unfinished TSO fence (code 4), forces `st_ok` to 0; an unfinished normal fence without sw does not block.
- R5: An older unfinished load (code 0) with acquire set, or an older unfinished store (code 1) with both acquire and release set, forces `st_ok` to 0.
- R6: With `st_rel` high, `st_ok` is 0 while any older valid slot is unfinished.
- R7: An older load or store whose `sb_addr_ok` is 0 forces `st_ok` to 0, even if finished.
- R8: Slots with `sb_valid` 0 or with an index at or above the candidate's position have no effect on `st_ok` or `fn_ok`.
- R9: For a normal fence, `fn_pr` high requires all older loads finished and `fn_pw` high requires all older stores finished; with neither set `fn_ok` is 1.
- R10: With `fn_tso` high, `fn_ok` is 1 only when all older loads and stores are finished, regardless of `fn_pr`/`fn_pw`.
- R11: A grant rises one clock after a cycle with request and permission, stays high until a cycle with acknowledge, then falls on the next clock.
- R12: During reset both grants are 0 and both handshakes return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_valid | input | N | Slot holds an instruction |
| sb_kind | input | N x 3 | Slot kind code: 0 load, 1 store, 2 branch/jump, 3 fence, 4 TSO fence, 5 other |
| sb_fbits | input | N x 4 | Fence bits: 3 pr, 2 pw, 1 sr, 0 sw |
| sb_acq | input | N | Acquire annotation |
| sb_rel | input | N | Release annotation |
| sb_done | input | N | Slot finished |
| sb_addr_ok | input | N | Address footprint known |
| st_pos | input | PW | Age position of the candidate store |
| st_data_rdy | input | 1 | Store data fully determined |
| st_rel | input | 1 | Candidate store is a release |
| st_req | input | 1 | Store commit request |
| st_ack | input | 1 | Store grant acknowledge |
| st_ok | output | 1 | Store may commit (combinational) |
| st_grant | output | 1 | Registered store commit grant |
| fn_pos | input | PW | Age position of the candidate fence |
| fn_pr | input | 1 | Candidate fence orders prior loads |
| fn_pw | input | 1 | Candidate fence orders prior stores |
| fn_tso | input | 1 | Candidate fence is a TSO fence |
| fn_req | input | 1 | Fence commit request |
| fn_ack | input | 1 | Fence grant acknowledge |
| fn_ok | output | 1 | Fence may commit (combinational) |
| fn_grant | output | 1 | Registered fence commit grant |

## Verification
The hardest situation to reach is a store whose permission hinges on a single slot that sits exactly at the age boundary or is invalid, for instance a release store blocked by one unfinished slot just below `st_pos` while many unfinished slots lie at or above it. Directed cases place one blocking slot at position minus one and then move the position down by one, and a long pseudo-random phase keeps most slots finished so that permission flips often and single-slot blockers arise frequently. A behavioural reference model scores every cycle, including handshakes where request, permission and acknowledge change together.

// File: rtl/commit_gate_pkg.sv
package commit_gate_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD   = 3'd0,
        KIND_STORE  = 3'd1,
        KIND_BRANCH = 3'd2,
        KIND_FENCE  = 3'd3,
        KIND_TSO    = 3'd4,
        KIND_OTHER  = 3'd5
    } slot_kind_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WAIT  = 2'd1,
        HS_GRANT = 2'd2
    } hs_state_e;

    localparam int FB_SW = 0;
    localparam int FB_SR = 1;
    localparam int FB_PW = 2;
    localparam int FB_PR = 3;

endpackage

// File: rtl/cg_slot_eval.sv
module cg_slot_eval
    import commit_gate_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]        sb_valid,
    input  logic [N-1:0][2:0]   sb_kind,
    input  logic [N-1:0][3:0]   sb_fbits,
    input  logic [N-1:0]        sb_acq,
    input  logic [N-1:0]        sb_rel,
    input  logic [N-1:0]        sb_done,
    input  logic [N-1:0]        sb_addr_ok,
    output logic [N-1:0]        open_ctrl,
    output logic [N-1:0]        open_wfence,
    output logic [N-1:0]        open_acq,
    output logic [N-1:0]        addr_unknown,
    output logic [N-1:0]        open_any,
    output logic [N-1:0]        open_load,
    output logic [N-1:0]        open_store
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        slot_kind_e k;
        logic       live;
        logic       is_ld;
        logic       is_st;

        assign k     = slot_kind_e'(sb_kind[i]);
        assign live  = sb_valid[i] & ~sb_done[i];
        assign is_ld = (k == KIND_LOAD);
        assign is_st = (k == KIND_STORE);

        assign open_ctrl[i]    = live & (k == KIND_BRANCH);
        assign open_wfence[i]  = live & (((k == KIND_FENCE) & sb_fbits[i][FB_SW])
                                         | (k == KIND_TSO));
        assign open_acq[i]     = live & ((is_ld & sb_acq[i])
                                         | (is_st & sb_acq[i] & sb_rel[i]));
        assign addr_unknown[i] = sb_valid[i] & (is_ld | is_st) & ~sb_addr_ok[i];
        assign open_any[i]     = live;
        assign open_load[i]    = live & is_ld;
        assign open_store[i]   = live & is_st;
    end

endmodule

// File: rtl/cg_store_rule.sv
module cg_store_rule #(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic [PW-1:0] pos,
    input  logic          data_rdy,
    input  logic          is_rel,
    input  logic [N-1:0]  open_ctrl,
    input  logic [N-1:0]  open_wfence,
    input  logic [N-1:0]  open_acq,
    input  logic [N-1:0]  addr_unknown,
    input  logic [N-1:0]  open_any,
    output logic          ok
);

    logic [N-1:0] older;
    logic [N-1:0] hard_block;

    for (genvar i = 0; i < N; i++) begin : g_age
        assign older[i] = (PW'(i) < pos);
    end

    assign hard_block = older & (open_ctrl | open_wfence | open_acq | addr_unknown);

    always_comb begin
        ok = data_rdy & ~(|hard_block);
        if (is_rel && |(older & open_any)) begin
            ok = 1'b0;
        end
    end

endmodule

// File: rtl/cg_fence_rule.sv
module cg_fence_rule #(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic [PW-1:0] pos,
    input  logic          ord_ld,
    input  logic          ord_st,
    input  logic          is_tso,
    input  logic [N-1:0]  open_load,
    input  logic [N-1:0]  open_store,
    output logic          ok
);

    logic [N-1:0] older;
    logic         need_ld;
    logic         need_st;

    for (genvar i = 0; i < N; i++) begin : g_age
        assign older[i] = (PW'(i) < pos);
    end

    assign need_ld = is_tso | ord_ld;
    assign need_st = is_tso | ord_st;

    always_comb begin
        ok = 1'b1;
        if (need_ld && |(older & open_load)) begin
            ok = 1'b0;
        end
        if (need_st && |(older & open_store)) begin
            ok = 1'b0;
        end
    end

endmodule

// File: rtl/cg_commit_fsm.sv
module cg_commit_fsm
    import commit_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic allowed,
    input  logic ack,
    output logic grant
);

    hs_state_e state_q;
    hs_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (req && allowed) begin
                    state_d = HS_GRANT;
                end else if (req) begin
                    state_d = HS_WAIT;
                end
            end
            HS_WAIT: begin
                if (req && allowed) begin
                    state_d = HS_GRANT;
                end else if (!req) begin
                    state_d = HS_IDLE;
                end
            end
            HS_GRANT: begin
                grant = 1'b1;
                if (ack) begin
                    state_d = HS_IDLE;
                end
            end
            default: begin
                state_d = HS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/commit_gate.sv
module commit_gate
    import commit_gate_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        sb_valid,
    input  logic [N-1:0][2:0]   sb_kind,
    input  logic [N-1:0][3:0]   sb_fbits,
    input  logic [N-1:0]        sb_acq,
    input  logic [N-1:0]        sb_rel,
    input  logic [N-1:0]        sb_done,
    input  logic [N-1:0]        sb_addr_ok,
    input  logic [PW-1:0]       st_pos,
    input  logic                st_data_rdy,
    input  logic                st_rel,
    input  logic                st_req,
    input  logic                st_ack,
    output logic                st_ok,
    output logic                st_grant,
    input  logic [PW-1:0]       fn_pos,
    input  logic                fn_pr,
    input  logic                fn_pw,
    input  logic                fn_tso,
    input  logic                fn_req,
    input  logic                fn_ack,
    output logic                fn_ok,
    output logic                fn_grant
);

    logic [N-1:0] open_ctrl;
    logic [N-1:0] open_wfence;
    logic [N-1:0] open_acq;
    logic [N-1:0] addr_unknown;
    logic [N-1:0] open_any;
    logic [N-1:0] open_load;
    logic [N-1:0] open_store;

    cg_slot_eval #(.N(N)) u_slots (
        .sb_valid     (sb_valid),
        .sb_kind      (sb_kind),
        .sb_fbits     (sb_fbits),
        .sb_acq       (sb_acq),
        .sb_rel       (sb_rel),
        .sb_done      (sb_done),
        .sb_addr_ok   (sb_addr_ok),
        .open_ctrl    (open_ctrl),
        .open_wfence  (open_wfence),
        .open_acq     (open_acq),
        .addr_unknown (addr_unknown),
        .open_any     (open_any),
        .open_load    (open_load),
        .open_store   (open_store)
    );

    cg_store_rule #(.N(N), .PW(PW)) u_store_rule (
        .pos          (st_pos),
        .data_rdy     (st_data_rdy),
        .is_rel       (st_rel),
        .open_ctrl    (open_ctrl),
        .open_wfence  (open_wfence),
        .open_acq     (open_acq),
        .addr_unknown (addr_unknown),
        .open_any     (open_any),
        .ok           (st_ok)
    );

    cg_fence_rule #(.N(N), .PW(PW)) u_fence_rule (
        .pos        (fn_pos),
        .ord_ld     (fn_pr),
        .ord_st     (fn_pw),
        .is_tso     (fn_tso),
        .open_load  (open_load),
        .open_store (open_store),
        .ok         (fn_ok)
    );

    cg_commit_fsm u_store_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (st_req),
        .allowed (st_ok),
        .ack     (st_ack),
        .grant   (st_grant)
    );

    cg_commit_fsm u_fence_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (fn_req),
        .allowed (fn_ok),
        .ack     (fn_ack),
        .grant   (fn_grant)
    );

endmodule

// File: rtl/commit_gate_chk.sv
module commit_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic st_data_rdy,
    input logic st_req,
    input logic st_ack,
    input logic st_ok,
    input logic st_grant,
    input logic fn_req,
    input logic fn_ack,
    input logic fn_ok,
    input logic fn_grant
);

    p_nodata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_data_rdy |-> !st_ok);

    p_st_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_grant && !st_ack) |=> st_grant);

    p_st_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_grant && st_ack) |=> !st_grant);

    p_st_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_grant) |-> $past(st_req && st_ok));

    p_fn_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_grant && !fn_ack) |=> fn_grant);

    p_fn_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fn_grant) |-> $past(fn_req && fn_ok));

    // R12: grants cleared on the edge after reset is seen
    p_reset_clear_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> (!st_grant && !fn_grant));

endmodule

bind commit_gate commit_gate_chk u_commit_gate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_data_rdy (st_data_rdy),
    .st_req      (st_req),
    .st_ack      (st_ack),
    .st_ok       (st_ok),
    .st_grant    (st_grant),
    .fn_req      (fn_req),
    .fn_ack      (fn_ack),
    .fn_ok       (fn_ok),
    .fn_grant    (fn_grant)
);

// File: tb/commit_gate_bench.sv
`timescale 1ns/100ps
module commit_gate_bench;

    localparam int N  = 8;
    localparam int PW = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        sb_valid = '0;
    logic [N-1:0][2:0]   sb_kind = '0;
    logic [N-1:0][3:0]   sb_fbits = '0;
    logic [N-1:0]        sb_acq = '0;
    logic [N-1:0]        sb_rel = '0;
    logic [N-1:0]        sb_done = '0;
    logic [N-1:0]        sb_addr_ok = '0;
    logic [PW-1:0]       st_pos = '0;
    logic                st_data_rdy = 1'b0;
    logic                st_rel = 1'b0;
    logic                st_req = 1'b0;
    logic                st_ack = 1'b0;
    logic                st_ok;
    logic                st_grant;
    logic [PW-1:0]       fn_pos = '0;
    logic                fn_pr = 1'b0;
    logic                fn_pw = 1'b0;
    logic                fn_tso = 1'b0;
    logic                fn_req = 1'b0;
    logic                fn_ack = 1'b0;
    logic                fn_ok;
    logic                fn_grant;

    int  vectors = 0;
    int  miscompares = 0;
    bit  m_st_g = 1'b0;
    bit  m_fn_g = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    commit_gate u_commit_gate (
        .clk (clk), .rst_n (rst_n),
        .sb_valid (sb_valid), .sb_kind (sb_kind), .sb_fbits (sb_fbits),
        .sb_acq (sb_acq), .sb_rel (sb_rel), .sb_done (sb_done),
        .sb_addr_ok (sb_addr_ok),
        .st_pos (st_pos), .st_data_rdy (st_data_rdy), .st_rel (st_rel),
        .st_req (st_req), .st_ack (st_ack), .st_ok (st_ok), .st_grant (st_grant),
        .fn_pos (fn_pos), .fn_pr (fn_pr), .fn_pw (fn_pw), .fn_tso (fn_tso),
        .fn_req (fn_req), .fn_ack (fn_ack), .fn_ok (fn_ok), .fn_grant (fn_grant)
    );

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    function automatic bit ref_store();
        if (!st_data_rdy) return 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sb_valid[i] && i < int'(st_pos)) begin
                int  k = int'(sb_kind[i]);
                bit  open = !sb_done[i];
                if ((k == 0 || k == 1) && !sb_addr_ok[i]) return 1'b0;
                if (open) begin
                    if (st_rel) return 1'b0;
                    if (k == 2) return 1'b0;
                    if (k == 4) return 1'b0;
                    if (k == 3 && sb_fbits[i][0]) return 1'b0;
                    if (k == 0 && sb_acq[i]) return 1'b0;
                    if (k == 1 && sb_acq[i] && sb_rel[i]) return 1'b0;
                end
            end
        end
        return 1'b1;
    endfunction

    function automatic bit ref_fence();
        for (int i = 0; i < N; i++) begin
            if (sb_valid[i] && i < int'(fn_pos) && !sb_done[i]) begin
                if (sb_kind[i] == 3'd0 && (fn_tso || fn_pr)) return 1'b0;
                if (sb_kind[i] == 3'd1 && (fn_tso || fn_pw)) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic cmp(input string tag, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare verdicts, advance model, compare grants
    task automatic step(input string tag);
        bit es, ef;
        #1;
        es = ref_store();
        ef = ref_fence();
        cmp({tag, " st_ok"}, st_ok, es);
        cmp({tag, " fn_ok"}, fn_ok, ef);
        m_st_g = m_st_g ? !st_ack : (st_req && es);
        m_fn_g = m_fn_g ? !fn_ack : (fn_req && ef);
        @(posedge clk);
        @(negedge clk);
        cmp("R11 st_grant", st_grant, m_st_g);
        cmp("R11 fn_grant", fn_grant, m_fn_g);
    endtask

    task automatic clear_sb();
        sb_valid = '0; sb_kind = '0; sb_fbits = '0; sb_acq = '0;
        sb_rel = '0; sb_done = '0; sb_addr_ok = '1;
        st_pos = PW'(N); fn_pos = PW'(N);
        st_data_rdy = 1'b1; st_rel = 1'b0;
        fn_pr = 1'b0; fn_pw = 1'b0; fn_tso = 1'b0;
        st_req = 1'b0; st_ack = 1'b0; fn_req = 1'b0; fn_ack = 1'b0;
    endtask

    task automatic put(input int i, input logic [2:0] k, input bit done);
        sb_valid[i] = 1'b1; sb_kind[i] = k; sb_done[i] = done;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        clear_sb();
        st_req = 1'b1; fn_req = 1'b1;
        repeat (3) @(negedge clk);
        cmp("R12 st_grant in reset", st_grant, 1'b0);
        cmp("R12 fn_grant in reset", fn_grant, 1'b0);
        st_req = 1'b0; fn_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty scoreboard, data ready
        clear_sb(); step("R1");
        cmp("R1 literal", st_ok, 1'b1);

        // R2: data not ready
        clear_sb(); st_data_rdy = 1'b0; step("R2");
        cmp("R2 literal", st_ok, 1'b0);

        // R3: unfinished branch just below position
        clear_sb(); put(3, 3'd2, 1'b0); st_pos = 4; step("R3");
        cmp("R3 literal", st_ok, 1'b0);
        sb_done[3] = 1'b1; step("R3 finished");
        cmp("R3 finished literal", st_ok, 1'b1);

        // R4: fence with sw, fence without sw, tso fence
        clear_sb(); put(1, 3'd3, 1'b0); sb_fbits[1] = 4'b0001; step("R4 sw");
        cmp("R4 sw literal", st_ok, 1'b0);
        sb_fbits[1] = 4'b1110; step("R4 no sw");
        cmp("R4 no sw literal", st_ok, 1'b1);
        clear_sb(); put(0, 3'd4, 1'b0); step("R4 tso");
        cmp("R4 tso literal", st_ok, 1'b0);

        // R5: load-acquire and store acq+rel
        clear_sb(); put(2, 3'd0, 1'b0); sb_acq[2] = 1'b1; step("R5 ld acq");
        cmp("R5 ld acq literal", st_ok, 1'b0);
        clear_sb(); put(2, 3'd1, 1'b0); sb_acq[2] = 1'b1; step("R5 st acq only");
        cmp("R5 st acq only literal", st_ok, 1'b1);
        sb_rel[2] = 1'b1; step("R5 st acqrel");
        cmp("R5 st acqrel literal", st_ok, 1'b0);

        // R6: release store with one unfinished plain slot
        clear_sb(); put(5, 3'd5, 1'b0); st_pos = 6; step("R6 plain");
        cmp("R6 nonrel literal", st_ok, 1'b1);
        st_rel = 1'b1; step("R6 rel");
        cmp("R6 rel literal", st_ok, 1'b0);
        st_pos = 5; step("R6 boundary");
        cmp("R8 boundary literal", st_ok, 1'b1);

        // R7: finished load with unknown address
        clear_sb(); put(4, 3'd0, 1'b1); sb_addr_ok[4] = 1'b0; step("R7");
        cmp("R7 literal", st_ok, 1'b0);

        // R8: invalid and younger slots ignored
        clear_sb(); put(6, 3'd2, 1'b0); st_pos = 6; fn_pos = 6;
        put(7, 3'd0, 1'b0); fn_tso = 1'b1; step("R8 younger");
        cmp("R8 st literal", st_ok, 1'b1);
        cmp("R8 fn literal", fn_ok, 1'b1);
        sb_valid = '0; sb_kind[0] = 3'd2; st_pos = 8; step("R8 invalid");
        cmp("R8 invalid literal", st_ok, 1'b1);

        // R9: pr/pw
        clear_sb(); put(0, 3'd0, 1'b0); put(1, 3'd1, 1'b1);
        step("R9 none"); cmp("R9 none literal", fn_ok, 1'b1);
        fn_pw = 1'b1; step("R9 pw"); cmp("R9 pw literal", fn_ok, 1'b1);
        fn_pr = 1'b1; step("R9 pr"); cmp("R9 pr literal", fn_ok, 1'b0);
        fn_pr = 1'b0; sb_done[1] = 1'b0; step("R9 pw open");
        cmp("R9 pw open literal", fn_ok, 1'b0);

        // R10: tso ignores pr/pw
        clear_sb(); put(2, 3'd1, 1'b0); fn_tso = 1'b1; step("R10 st open");
        cmp("R10 literal", fn_ok, 1'b0);
        sb_done[2] = 1'b1; step("R10 done");
        cmp("R10 done literal", fn_ok, 1'b1);

        // R11: handshake rise, hold, fall, both at once
        clear_sb(); st_req = 1'b1; fn_req = 1'b1; step("R11 req");
        cmp("R11 st rise", st_grant, 1'b1);
        cmp("R11 fn rise", fn_grant, 1'b1);
        st_req = 1'b0; step("R11 hold");
        cmp("R11 st hold", st_grant, 1'b1);
        st_ack = 1'b1; fn_ack = 1'b1; step("R11 ack");
        cmp("R11 st fall", st_grant, 1'b0);
        cmp("R11 fn fall", fn_grant, 1'b0);
        st_ack = 1'b0; fn_ack = 1'b0; st_req = 1'b1; st_data_rdy = 1'b0;
        step("R11 wait");
        cmp("R11 wait no grant", st_grant, 1'b0);
        st_data_rdy = 1'b1; step("R11 wait to grant");
        cmp("R11 late grant", st_grant, 1'b1);
        st_ack = 1'b1; step("R11 clear");

        // random phase, all requirements scored by the model
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                sb_valid[i]   = (rnd() % 5) != 0;
                sb_kind[i]    = 3'(rnd() % 6);
                sb_fbits[i]   = 4'(rnd());
                sb_acq[i]     = (rnd() % 4) == 0;
                sb_rel[i]     = (rnd() % 4) == 0;
                sb_done[i]    = (rnd() % 5) != 0;
                sb_addr_ok[i] = (rnd() % 8) != 0;
            end
            st_pos      = PW'(rnd() % (N + 1));
            fn_pos      = PW'(rnd() % (N + 1));
            st_data_rdy = (rnd() % 8) != 0;
            st_rel      = (rnd() % 4) == 0;
            fn_pr       = rnd() % 2 == 0;
            fn_pw       = rnd() % 2 == 0;
            fn_tso      = (rnd() % 4) == 0;
            st_req      = rnd() % 2 == 0;
            fn_req      = rnd() % 2 == 0;
            st_ack      = rnd() % 2 == 0;
            fn_ack      = rnd() % 2 == 0;
            step("R8 random");
        end

        // reset in the middle of a grant
        clear_sb(); st_req = 1'b1; fn_req = 1'b1; step("R12 pre");
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        cmp("R12 st after reset", st_grant, 1'b0);
        cmp("R12 fn after reset", fn_grant, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule